// File: doc/BRIEF.md
# Beacon Timer Unit with Microsecond Time Base

The block keeps a 64-bit microsecond time base and four comparison timers that mark the moments around each beacon period. The time base advances once per microsecond tick from an enable input. Software can load it 32 bits at a time or clear it. Two timers count in whole time units (1 TU = 1024 µs): the next beacon target and the end of the announcement window. The other two count in eighths of a time unit: the early DMA alert and the software alert. Each timer is compared with a bit slice of the time base. On an exact match the timer raises a one-cycle event and moves forward by the beacon interval.

Configuration goes through a simple write port with a 3-bit word address. The time base can be read directly on an output bus. Software normally sets the alerts to (next beacon − lead) × 8, where the lead is in TU, and the window end to next beacon + 1. In station mode it parks both alerts at all-ones values.

Timers follow only exact equality. If the time base jumps past a timer, that timer stays stale until the 16-bit TU count wraps round to it again. The clear request behaves as a toggle, so a second write is needed to withdraw it.

Top module: `bcn_timer_unit`

## Requirements
- R1: After reset the time base reads zero, the beacon enable and the clear-request flag are clear, and no event output is high.
- R2: The time base increases by one on each clock where `usTick` is high and no write changes it. It holds when `usTick` is low. It wraps from all ones to zero.
- R3: A write to address 0 replaces bits 31:0 of the time base and a write to address 1 replaces bits 63:32. The other half is kept. Such a write takes precedence over a tick in the same cycle, and counting resumes from the loaded value.
- R4: A write to address 2 with bit 1 set toggles an internal clear request. The time base is cleared only when that toggle sets the request; a toggle that withdraws it leaves the time base alone. A write to address 2 with bit 1 clear never changes the time base.
- R5: The next-beacon timer (address 4) and the window-end timer (address 7) hold 16-bit TU values. Each is compared with time-base bits 25:10. On equality, the timer's event goes high on the following clock, and the timer adds the beacon interval (address 3, 16 bits) modulo 2^16.
- R6: The DMA-alert timer (address 5) and the software-alert timer (address 6) hold 19-bit eighth-TU values. Each is compared with time-base bits 25:7 and advances by the interval times 8 on a match.
- R7: Each event is a single-cycle pulse. Events appear only while the beacon enable (address 2, bit 0) is set. Timers keep advancing on matches while events are disabled.
- R8: A timer whose value the time base has jumped past does not fire or advance until the TU count wraps and equals it again.
- R9: An alert timer written with its low 16 bits all ones (0x0FFFF or 0x7FFFF) is parked: it never matches, never advances and never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-microsecond tick enable |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 3 | Word address of the write |
| wrData | input | 32 | Write data |
| tsf | output | 64 | Current time base in µs |
| evNextBcn | output | 1 | Next-beacon event pulse |
| evDmaAlert | output | 1 | DMA-alert event pulse |
| evSwAlert | output | 1 | Software-alert event pulse |
| evAtimEnd | output | 1 | Announcement-window end event pulse |

## Verification
A timer that holds a wrong value, or that advances by the wrong step, shows up at the next expected match. At that point its pulse is missing, or it comes with a time base that differs from the timer value times the unit plus one. The bench therefore tracks each timer's expected firing moment in microseconds and compares every pulse with it over several intervals. A wrong clear-request flag shows one write later, when a clear write leaves the time base where it was, or when a withdrawing write wipes it. A wrong park bit shows as an alert pulse within 128 µs of the parked value.

// File: rtl/bcn_pkg.sv
package bcn_pkg;
  localparam int TSF_W   = 64;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int NUM_TMR = 4;

  // timer indices; the alert timers count in eighth-TU units
  localparam int TMR_NEXT = 0;
  localparam int TMR_DMA  = 1;
  localparam int TMR_SW   = 2;
  localparam int TMR_ATIM = 3;

  // write-port word addresses
  localparam int ADR_TSF_LO   = 0;
  localparam int ADR_TSF_HI   = 1;
  localparam int ADR_CTRL     = 2;
  localparam int ADR_INTERVAL = 3;
  localparam int ADR_TMR_BASE = 4;

  typedef struct packed {
    logic               loadLo;
    logic               loadHi;
    logic               clearTsf;
    logic               setIntv;
    logic [NUM_TMR-1:0] setTimer;
  } dpStrobe_t;
endpackage

// File: rtl/bcn_ctrl.sv
module bcn_ctrl
  import bcn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output dpStrobe_t         stb,
  output logic              bcnEnable,
  output logic              rstReq
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(ADR_CTRL));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bcnEnable <= 1'b0;
      rstReq    <= 1'b0;
    end else if (ctrlWr) begin
      bcnEnable <= wrData[0];
      if (wrData[1]) rstReq <= ~rstReq;
    end
  end

  always_comb begin
    stb          = '0;
    stb.loadLo   = wrEn && (wrAddr == ADDR_W'(ADR_TSF_LO));
    stb.loadHi   = wrEn && (wrAddr == ADDR_W'(ADR_TSF_HI));
    stb.setIntv  = wrEn && (wrAddr == ADDR_W'(ADR_INTERVAL));
    // clear only on the toggle that raises the request
    stb.clearTsf = ctrlWr && wrData[1] && !rstReq;
    for (int i = 0; i < NUM_TMR; i++)
      stb.setTimer[i] = wrEn && (wrAddr == ADDR_W'(ADR_TMR_BASE + i));
  end
endmodule

// File: rtl/bcn_dp.sv
module bcn_dp
  import bcn_pkg::*;
#(
  parameter int TU_SHIFT = 10,
  parameter int CMP_W    = 16,
  parameter int FRAC_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               usTick,
  input  dpStrobe_t          stb,
  input  logic [REG_W-1:0]   wrData,
  input  logic               bcnEnable,
  output logic [TSF_W-1:0]   tsf,
  output logic [NUM_TMR-1:0] ev
);
  localparam int HALF_W = TSF_W / 2;

  logic [CMP_W-1:0]   interval;
  logic [NUM_TMR-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsf <= '0;
    end else if (stb.clearTsf) begin
      tsf <= '0;
    end else if (stb.loadLo || stb.loadHi) begin
      if (stb.loadLo) tsf[HALF_W-1:0]     <= wrData[HALF_W-1:0];
      if (stb.loadHi) tsf[TSF_W-1:HALF_W] <= wrData[HALF_W-1:0];
    end else if (usTick) begin
      tsf <= tsf + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            interval <= '0;
    else if (stb.setIntv) interval <= wrData[CMP_W-1:0];
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam bit EIGHTH = (i == TMR_DMA) || (i == TMR_SW);
    localparam int W      = EIGHTH ? CMP_W + FRAC_W : CMP_W;
    localparam int SH     = EIGHTH ? TU_SHIFT - FRAC_W : TU_SHIFT;

    logic [W-1:0] tmr;
    logic [W-1:0] step;
    logic         parked;

    assign step      = W'(interval) << (W - CMP_W);
    assign hitVec[i] = !parked && (tsf[SH +: W] == tmr);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tmr    <= '0;
        parked <= 1'b0;
      end else if (stb.setTimer[i]) begin
        tmr    <= wrData[W-1:0];
        parked <= EIGHTH && (&wrData[CMP_W-1:0]);
      end else if (hitVec[i]) begin
        tmr <= tmr + step;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ev <= '0;
    else       ev <= hitVec & {NUM_TMR{bcnEnable}};
  end
endmodule

// File: rtl/bcn_timer_unit.sv
module bcn_timer_unit
  import bcn_pkg::*;
#(
  parameter int TU_SHIFT = 10,
  parameter int CMP_W    = 16,
  parameter int FRAC_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output logic [TSF_W-1:0]  tsf,
  output logic              evNextBcn,
  output logic              evDmaAlert,
  output logic              evSwAlert,
  output logic              evAtimEnd
);
  dpStrobe_t          stb;
  logic               bcnEnable;
  logic               rstReq;
  logic [NUM_TMR-1:0] ev;

  bcn_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stb(stb), .bcnEnable(bcnEnable), .rstReq(rstReq)
  );

  bcn_dp #(.TU_SHIFT(TU_SHIFT), .CMP_W(CMP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .usTick(usTick), .stb(stb), .wrData(wrData),
    .bcnEnable(bcnEnable), .tsf(tsf), .ev(ev)
  );

  assign evNextBcn  = ev[TMR_NEXT];
  assign evDmaAlert = ev[TMR_DMA];
  assign evSwAlert  = ev[TMR_SW];
  assign evAtimEnd  = ev[TMR_ATIM];
endmodule

// File: rtl/bcn_timer_checker.sv
module bcn_timer_checker
  import bcn_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              usTick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [REG_W-1:0]  wrData,
  input logic [TSF_W-1:0]  tsf,
  input logic [3:0]        evAll,
  input logic              bcnEnable,
  input logic              rstReq
);
  a_r2_tick_inc: assert property (@(posedge clk) disable iff (!rstN)
    usTick && !wrEn |=> tsf == $past(tsf) + 64'd1);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !usTick && !wrEn |=> $stable(tsf));

  a_r3_low_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr == 3'd0 |=> tsf[31:0] == $past(wrData));

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr == 3'd2 && wrData[1] |=> rstReq != $past(rstReq));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr == 3'd2 && wrData[1] && !rstReq |=> tsf == 64'd0);

  a_r7_gated: assert property (@(posedge clk) disable iff (!rstN)
    (|evAll) |-> $past(bcnEnable));
endmodule

bind bcn_timer_unit bcn_timer_checker u_chk (
  .clk(clk), .rstN(rstN), .usTick(usTick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .tsf(tsf),
  .evAll({evAtimEnd, evSwAlert, evDmaAlert, evNextBcn}),
  .bcnEnable(bcnEnable), .rstReq(rstReq)
);

// File: tb/bcn_timer_unit_bench.sv
`timescale 1ns/1ps
module bcn_timer_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [63:0] tsf;
  logic        evNextBcn, evDmaAlert, evSwAlert, evAtimEnd;
  logic [3:0]  evVec;

  int nChecks = 0;
  int nFail   = 0;

  bit              monOn   = 1'b0;
  bit              enModel = 1'b0;
  longint unsigned expNext [4];
  longint unsigned stepUs  [4];

  always #4 clk = ~clk;

  bcn_timer_unit u_bcn_timer_unit (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .tsf(tsf), .evNextBcn(evNextBcn), .evDmaAlert(evDmaAlert),
    .evSwAlert(evSwAlert), .evAtimEnd(evAtimEnd)
  );

  assign evVec = {evAtimEnd, evSwAlert, evDmaAlert, evNextBcn};

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runCount(input int n, output int c0, output int c1,
                          output int c2, output longint unsigned t0);
    c0 = 0; c1 = 0; c2 = 0; t0 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (evNextBcn) begin c0++; t0 = tsf; end
      if (evDmaAlert) c1++;
      if (evSwAlert)  c2++;
    end
  endtask

  // per-timer expected firing moments in microseconds (R5, R6, R7)
  always @(negedge clk) begin
    if (monOn) begin
      for (int i = 0; i < 4; i++) begin
        bit due;
        due = (tsf == expNext[i] + 1);
        if ((due && enModel) || evVec[i])
          chk(evVec[i] == (due && enModel), $sformatf("R5/R6/R7 timer%0d pulse at tsf", i),
              tsf, expNext[i] + 1);
        if (due) expNext[i] += stepUs[i];
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int c0, c1, c2;
    longint unsigned t0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    repeat (10) @(negedge clk);
    chk(tsf == 0, "R1 tsf after reset", tsf, 0);
    chk(evVec == 0, "R1 events after reset", evVec, 0);

    // R2: counting on ticks
    usTick = 1'b1;
    repeat (25) @(negedge clk);
    usTick = 1'b0;
    chk(tsf == 25, "R2 tick count", tsf, 25);
    repeat (5) @(negedge clk);
    chk(tsf == 25, "R2 hold without tick", tsf, 25);

    // R3: half loads and carry across halves
    wr(0, 32'hFFFF_FFF0);
    wr(1, 32'h0000_0012);
    chk(tsf == 64'h12_FFFF_FFF0, "R3 half loads", tsf, 64'h12_FFFF_FFF0);
    usTick = 1'b1;
    repeat (20) @(negedge clk);
    usTick = 1'b0;
    chk(tsf == 64'h13_0000_0004, "R3 count into upper half", tsf, 64'h13_0000_0004);
    usTick = 1'b1;
    wr(0, 32'd100);
    chk(tsf == 64'h13_0000_0064, "R3 load beats tick", tsf, 64'h13_0000_0064);
    @(negedge clk);
    usTick = 1'b0;
    chk(tsf == 64'h13_0000_0065, "R3 count resumes", tsf, 64'h13_0000_0065);

    // R2: wrap
    wr(1, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFE);
    usTick = 1'b1;
    repeat (3) @(negedge clk);
    usTick = 1'b0;
    chk(tsf == 1, "R2 64-bit wrap", tsf, 1);

    // R4: clear request toggles
    wr(0, 32'd777);
    wr(2, 32'h0);
    chk(tsf == 777, "R4 control write without clear bit", tsf, 777);
    wr(2, 32'h2);
    chk(tsf == 0, "R4 first toggle clears", tsf, 0);
    wr(0, 32'd500);
    wr(2, 32'h2);
    chk(tsf == 500, "R4 second toggle leaves tsf", tsf, 500);
    wr(2, 32'h2);
    chk(tsf == 0, "R4 third toggle clears", tsf, 0);

    // R5/R6/R7: interval sweep, interval 3 TU
    wr(3, 32'd3);
    wr(4, 32'd2);
    wr(5, 32'd8);
    wr(6, 32'd12);
    wr(7, 32'd3);
    wr(0, 32'd0);
    wr(1, 32'd0);
    expNext[0] = 2 * 1024;  stepUs[0] = 3 * 1024;
    expNext[1] = 8 * 128;   stepUs[1] = 3 * 1024;
    expNext[2] = 12 * 128;  stepUs[2] = 3 * 1024;
    expNext[3] = 3 * 1024;  stepUs[3] = 3 * 1024;
    wr(2, 32'h1);
    enModel = 1'b1;
    monOn   = 1'b1;
    usTick  = 1'b1;
    repeat (7 * 1024 + 256) @(negedge clk);
    // R7: disabled window, timers keep advancing
    wr(2, 32'h0);
    enModel = 1'b0;
    repeat (3 * 1024) @(negedge clk);
    wr(2, 32'h1);
    enModel = 1'b1;
    repeat (4 * 1024) @(negedge clk);
    monOn  = 1'b0;
    usTick = 1'b0;
    chk(expNext[0] > 12 * 1024, "R5 next-beacon timer fired repeatedly", expNext[0], 14 * 1024);

    // R8 stale timer, R9 parked alerts
    wr(4, 32'd5);
    wr(5, 32'h0000_FFFF);
    wr(6, 32'h0007_FFFF);
    wr(7, 32'h7000);
    wr(0, 32'd6 * 1024);
    usTick = 1'b1;
    runCount(3 * 1024, c0, c1, c2, t0);
    usTick = 1'b0;
    chk(c0 == 0, "R8 stale timer silent after jump", c0, 0);
    chk(c1 == 0 && c2 == 0, "R9 parked alerts silent", c1 + c2, 0);
    wr(0, 32'd65541 * 1024 - 4);
    usTick = 1'b1;
    runCount(10, c0, c1, c2, t0);
    usTick = 1'b0;
    chk(c0 == 1, "R8 fires once after TU wrap", c0, 1);
    chk(t0 == 65541 * 1024 + 1, "R8 firing moment after wrap", t0, 65541 * 1024 + 1);

    wr(0, 32'h0000_FFFF * 128 - 4);
    usTick = 1'b1;
    runCount(10, c0, c1, c2, t0);
    usTick = 1'b0;
    chk(c1 == 0, "R9 DMA alert parked at 0xFFFF", c1, 0);
    wr(0, 32'h0007_FFFF * 128 - 4);
    usTick = 1'b1;
    runCount(10, c0, c1, c2, t0);
    usTick = 1'b0;
    chk(c2 == 0, "R9 software alert parked at 0x7FFFF", c2, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule